// File: doc/BRIEF.md
# H-Bridge Phase Driver with Overload Retry

This block turns a single logic-level track bit into two complementary gate drives for a MOSFET full bridge. Every change of the bit first turns off the leg that is conducting. It then holds both legs off for a programmable dead time before it turns on the opposite leg, so the bridge never shoots through. A registered copy of the track bit is also provided as a logic-level output, and it keeps following the input in every state.

An active-low overcurrent sense is resynchronised. It feeds a counter that measures how long the fault has lasted without a break. When the fault has lasted the full timeout, the next track-bit transition shuts the bridge down: both legs are forced off and an overload alarm is raised. After a fixed retry interval the alarm drops and the bridge comes back under the dead-time rule. The timeout count then starts again from zero. The dead time, timeout and retry interval are parameters counted in system clock cycles.

Top module: `hbridge_phase_drv`

## Requirements
- R1: `dcc_out` equals the value `dcc_in` had at the previous active clock edge, in normal drive and during shutdown alike.
- R2: When the level goes from 0 to 1, `ph2_drv` goes low in the same cycle that `dcc_out` rises. `ph1_drv` goes high `DEAD_CYC` clock edges later if the level does not change again.
- R3: When the level goes from 1 to 0, `ph1_drv` goes low in the same cycle that `dcc_out` falls. `ph2_drv` goes high `DEAD_CYC` clock edges later if the level does not change again.
- R4: `ph1_drv` and `ph2_drv` are never high together. `ph1_drv` is high only while `dcc_out` is 1, and `ph2_drv` only while `dcc_out` is 0.
- R5: A level change that arrives while a dead time is running restarts the wait. Both legs stay off until `DEAD_CYC` edges have passed after the most recent change.
- R6: While `rst_n` is low, both legs are off and `ovl_alarm` and `dcc_out` are 0. Reset is released through a two-stage synchroniser. With `dcc_in` held at 0, `ph2_drv` rises at clock edge `DEAD_CYC+2` after `rst_n` goes high.
- R7: `ocs_n` low means overcurrent, and it passes through two synchroniser stages. Suppose `ocs_n` is first low at edge 1 and stays low. A transition sampled at edge `OVL_TMO_CYC+3` or later causes a shutdown. A transition sampled at edge `OVL_TMO_CYC+2` does not.
- R8: An overcurrent with no transition of `dcc_in` never causes a shutdown, however long it lasts. The bridge keeps driving.
- R9: A shutdown forces both legs off and sets `ovl_alarm` from the cycle after the tripping edge. `ovl_alarm` stays high for exactly `RETRY_CYC` cycles.
- R10: After `ovl_alarm` falls, the leg that matches `dcc_out` turns on `DEAD_CYC` edges later. The fault count restarts from zero, so if the sense stays active, a transition sampled `OVL_TMO_CYC` edges after the alarm fell does not trip.
- R11: Transitions of `dcc_in` during shutdown are tracked on `dcc_out` and leave both legs off.
- R12: A sense pulse that ends before the timeout is reached leaves the count at zero. Transitions that follow it drive the bridge normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dcc_in | input | 1 | Logic-level track bit to be driven |
| ocs_n | input | 1 | Overcurrent sense, low while the bridge current is excessive |
| ph1_drv | output | 1 | Gate drive for the leg that drives the track high |
| ph2_drv | output | 1 | Gate drive for the leg that drives the track low |
| dcc_out | output | 1 | Registered logic-level copy of the track bit |
| ovl_alarm | output | 1 | High while the bridge is shut down after an overload |

## Verification
The hardest cases to reach are the trip decision one edge either side of the timeout and the restart of the count just after a retry. Both need a fault held for an exact number of cycles, with a transition landing on a chosen edge. The bench uses a short timeout and counts edges from the cycle in which `ocs_n` falls. It places a transition one edge before and one edge after the trip threshold. It then keeps the sense active through the retry window and toggles the input during shutdown. This checks that the count began again at zero and that the input was still being tracked. A sweep of toggle gaps from one cycle to past the dead time covers the restart of the dead time in both directions.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  typedef enum logic {
    OVL_RUN  = 1'b0,
    OVL_SHUT = 1'b1
  } ovl_state_e;
endpackage

// File: rtl/hbd_rst_sync.sv
module hbd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ni
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_ni = sh_q[STAGES-1];
endmodule

// File: rtl/hbd_sense_sync.sv
module hbd_sense_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ocs_n,
  output logic ovl_act
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], ocs_n};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= sh_d;
  end

  assign ovl_act = ~sh_q[STAGES-1];
endmodule

// File: rtl/hbd_ovl_mon.sv
module hbd_ovl_mon
  import hbd_pkg::*;
#(
  parameter int TMO_CYC   = 1048576,
  parameter int RETRY_CYC = 4000000
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic ovl_act,
  input  logic xition,
  output logic shut
);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam logic [TW-1:0] TMO_LAST   = TW'(TMO_CYC - 1);
  localparam logic [RW-1:0] RETRY_LAST = RW'(RETRY_CYC - 1);

  ovl_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmo_q, tmo_d;
  logic [RW-1:0] rty_q, rty_d;
  logic          tmr_en, rty_en;
  logic          trip;

  always_comb begin
    trip   = (st_q == OVL_RUN) && xition && tmo_q && ovl_act;
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmo_d  = tmo_q;
    rty_d  = rty_q;
    tmr_en = 1'b0;
    rty_en = 1'b0;
    unique case (st_q)
      OVL_RUN: begin
        tmr_en = 1'b1;
        if (trip) begin
          st_d   = OVL_SHUT;
          tmr_d  = '0;
          tmo_d  = 1'b0;
          rty_en = 1'b1;
          rty_d  = RETRY_LAST;
        end else if (!ovl_act) begin
          tmr_d = '0;
          tmo_d = 1'b0;
        end else if (tmr_q == TMO_LAST) begin
          tmo_d = 1'b1;
        end else begin
          tmr_d = tmr_q + 1'b1;
        end
      end
      OVL_SHUT: begin
        tmr_en = 1'b1;
        tmr_d  = '0;
        tmo_d  = 1'b0;
        if (rty_q == '0) begin
          st_d = OVL_RUN;
        end else begin
          rty_en = 1'b1;
          rty_d  = rty_q - 1'b1;
        end
      end
      default: st_d = OVL_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= OVL_RUN;
      tmr_q <= '0;
      tmo_q <= 1'b0;
      rty_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) begin
        tmr_q <= tmr_d;
        tmo_q <= tmo_d;
      end
      if (rty_en) rty_q <= rty_d;
    end
  end

  assign shut = (st_q == OVL_SHUT);
endmodule

// File: rtl/hbd_phase_seq.sv
module hbd_phase_seq #(
  parameter int DEAD_CYC = 32
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic dcc_in,
  input  logic shut,
  output logic lvl,
  output logic xition,
  output logic ph_hi,
  output logic ph_lo
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] DEAD_LAST = CW'(DEAD_CYC - 1);

  logic          lvl_q, lvl_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hi_q, hi_d, lo_q, lo_d;
  logic          cnt_en;

  always_comb begin
    xition = dcc_in ^ lvl_q;
    lvl_d  = dcc_in;
    pend_d = pend_q;
    cnt_d  = cnt_q;
    hi_d   = hi_q;
    lo_d   = lo_q;
    cnt_en = 1'b0;
    if (xition || shut) begin
      hi_d   = 1'b0;
      lo_d   = 1'b0;
      pend_d = 1'b1;
      cnt_en = 1'b1;
      cnt_d  = DEAD_LAST;
    end else if (pend_q) begin
      if (cnt_q == '0) begin
        hi_d   = lvl_q;
        lo_d   = ~lvl_q;
        pend_d = 1'b0;
      end else begin
        cnt_en = 1'b1;
        cnt_d  = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      pend_q <= 1'b1;
      cnt_q  <= DEAD_LAST;
      hi_q   <= 1'b0;
      lo_q   <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      pend_q <= pend_d;
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign lvl   = lvl_q;
  assign ph_hi = hi_q;
  assign ph_lo = lo_q;
endmodule

// File: rtl/hbridge_phase_drv.sv
module hbridge_phase_drv #(
  parameter int DEAD_CYC    = 32,
  parameter int OVL_TMO_CYC = 1048576,
  parameter int RETRY_CYC   = 4000000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dcc_in,
  input  logic ocs_n,
  output logic ph1_drv,
  output logic ph2_drv,
  output logic dcc_out,
  output logic ovl_alarm
);
  logic rst_ni;
  logic ovl_act;
  logic xition;
  logic shut;

  hbd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ni (rst_ni)
  );

  hbd_sense_sync #(.STAGES(SYNC_STAGES)) u_sense_sync (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ocs_n   (ocs_n),
    .ovl_act (ovl_act)
  );

  hbd_ovl_mon #(.TMO_CYC(OVL_TMO_CYC), .RETRY_CYC(RETRY_CYC)) u_ovl_mon (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .ovl_act (ovl_act),
    .xition  (xition),
    .shut    (shut)
  );

  hbd_phase_seq #(.DEAD_CYC(DEAD_CYC)) u_phase_seq (
    .clk    (clk),
    .rst_ni (rst_ni),
    .dcc_in (dcc_in),
    .shut   (shut),
    .lvl    (dcc_out),
    .xition (xition),
    .ph_hi  (ph1_drv),
    .ph_lo  (ph2_drv)
  );

  assign ovl_alarm = shut;
endmodule

// File: rtl/hbridge_phase_drv_chk.sv
module hbridge_phase_drv_chk #(
  parameter int DEAD_CYC  = 32,
  parameter int RETRY_CYC = 4000000
) (
  input logic clk,
  input logic rst_ni,
  input logic dcc_in,
  input logic ph1_drv,
  input logic ph2_drv,
  input logic dcc_out,
  input logic ovl_alarm
);
  localparam int OW = $clog2(DEAD_CYC + 1);

  logic          seen_q;
  logic [OW-1:0] off_run;
  logic [31:0]   al_run;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q  <= 1'b0;
      off_run <= '0;
      al_run  <= '0;
    end else begin
      seen_q <= 1'b1;
      if (ph1_drv || ph2_drv)              off_run <= '0;
      else if (off_run != OW'(DEAD_CYC))   off_run <= off_run + 1'b1;
      if (ovl_alarm) al_run <= al_run + 1'b1;
      else           al_run <= '0;
    end
  end

  // R1: registered copy of the input bit
  a_r1_follow: assert property (@(posedge clk) disable iff (!rst_ni)
    seen_q |-> (dcc_out == $past(dcc_in)));

  // R4: legs never conduct together
  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_ni)
    !(ph1_drv && ph2_drv));

  // R4: each leg matches the level
  a_r4_hi_level: assert property (@(posedge clk) disable iff (!rst_ni)
    ph1_drv |-> dcc_out);
  a_r4_lo_level: assert property (@(posedge clk) disable iff (!rst_ni)
    ph2_drv |-> !dcc_out);

  // R2: high leg turns on only after a full dead time
  a_r2_dead_hi: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ph1_drv) |-> (off_run >= OW'(DEAD_CYC)));

  // R3: low leg turns on only after a full dead time
  a_r3_dead_lo: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ph2_drv) |-> (off_run >= OW'(DEAD_CYC)));

  // R9: bridge off during alarm, alarm lasts the retry interval
  a_r9_alarm_off: assert property (@(posedge clk) disable iff (!rst_ni)
    ovl_alarm |-> (!ph1_drv && !ph2_drv));
  a_r9_alarm_len: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(ovl_alarm) |-> (al_run == 32'(RETRY_CYC)));
endmodule

bind hbridge_phase_drv hbridge_phase_drv_chk #(
  .DEAD_CYC  (DEAD_CYC),
  .RETRY_CYC (RETRY_CYC)
) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .dcc_in    (dcc_in),
  .ph1_drv   (ph1_drv),
  .ph2_drv   (ph2_drv),
  .dcc_out   (dcc_out),
  .ovl_alarm (ovl_alarm)
);

// File: tb/hbridge_phase_drv_bench.sv
module hbridge_phase_drv_bench;
  localparam int DEAD  = 4;
  localparam int TMO   = 20;
  localparam int RETRY = 30;

  logic clk = 1'b0;
  logic rst_n, dcc_in, ocs_n;
  logic ph1_drv, ph2_drv, dcc_out, ovl_alarm;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  int since;
  int al_left;
  bit m_lvl;

  always #2 clk = ~clk;

  hbridge_phase_drv #(
    .DEAD_CYC(DEAD), .OVL_TMO_CYC(TMO), .RETRY_CYC(RETRY), .SYNC_STAGES(2)
  ) u_hbridge_phase_drv (
    .clk(clk), .rst_n(rst_n), .dcc_in(dcc_in), .ocs_n(ocs_n),
    .ph1_drv(ph1_drv), .ph2_drv(ph2_drv), .dcc_out(dcc_out), .ovl_alarm(ovl_alarm)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock edge: inputs applied at a falling edge, outputs sampled at the next one
  task automatic cyc(input bit d, input bit s, input bit trip, input string tag);
    bit cleared;
    dcc_in = d;
    ocs_n  = s;
    @(negedge clk);
    cleared = 1'b0;
    if (trip) al_left = RETRY;
    else if (al_left > 0) begin
      al_left--;
      if (al_left == 0) cleared = 1'b1;
    end
    if (d != m_lvl || cleared) since = 0;
    else since++;
    m_lvl = d;
    chk("R1", "dcc_out", dcc_out, d);
    chk(tag, "ovl_alarm", ovl_alarm, al_left > 0);
    chk(tag, "ph1_drv", ph1_drv, (al_left == 0) && m_lvl && since >= DEAD);
    chk(tag, "ph2_drv", ph2_drv, (al_left == 0) && !m_lvl && since >= DEAD);
  endtask

  initial begin
    rst_n = 1'b0; dcc_in = 1'b0; ocs_n = 1'b1;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk("R6", "ph1_drv", ph1_drv, 1'b0);
    chk("R6", "ph2_drv", ph2_drv, 1'b0);
    chk("R6", "ovl_alarm", ovl_alarm, 1'b0);
    chk("R6", "dcc_out", dcc_out, 1'b0);
    rst_n = 1'b1;
    since = -2; al_left = 0; m_lvl = 1'b0;
    for (int i = 0; i < DEAD + 4; i++) cyc(1'b0, 1'b1, 1'b0, "R6");

    // R2 R3 R5: sweep toggle gaps in both directions
    for (int pol = 0; pol < 2; pol++) begin
      for (int g = 1; g <= DEAD + 3; g++) begin
        for (int i = 0; i < g; i++) cyc(~m_lvl ? 1'b1 : 1'b0, 1'b1, 1'b0, "R2 R3 R4 R5");
        begin
          bit back;
          back = ~m_lvl;
          for (int i = 0; i < DEAD + 2; i++) cyc(back, 1'b1, 1'b0, "R2 R3 R4 R5");
        end
      end
      cyc(~m_lvl, 1'b1, 1'b0, "R2 R3");
      for (int i = 0; i < DEAD + 1; i++) cyc(m_lvl, 1'b1, 1'b0, "R2 R3");
    end

    // R8: long fault without transitions keeps driving
    for (int i = 0; i < 3 * TMO; i++) cyc(m_lvl, 1'b0, 1'b0, "R8");
    for (int i = 0; i < DEAD; i++) cyc(m_lvl, 1'b1, 1'b0, "R8");

    // R12: short fault then transitions
    for (int i = 0; i < TMO / 2; i++) cyc(m_lvl, 1'b0, 1'b0, "R12");
    for (int i = 0; i < 3; i++) cyc(m_lvl, 1'b1, 1'b0, "R12");
    for (int k = 0; k < 4; k++) begin
      cyc(~m_lvl, 1'b1, 1'b0, "R12");
      for (int i = 0; i < DEAD + 1; i++) cyc(m_lvl, 1'b1, 1'b0, "R12");
    end

    // R7: transition one edge before the threshold does not trip
    for (int e = 1; e <= TMO + 1; e++) cyc(m_lvl, 1'b0, 1'b0, "R7");
    cyc(~m_lvl, 1'b0, 1'b0, "R7");
    for (int i = 0; i < DEAD + 4; i++) cyc(m_lvl, 1'b1, 1'b0, "R7");

    // R7 R9: transition at the threshold trips
    for (int e = 1; e <= TMO + 2; e++) cyc(m_lvl, 1'b0, 1'b0, "R7");
    cyc(~m_lvl, 1'b0, 1'b1, "R7 R9");
    // R11: toggles during shutdown, sense still active
    for (int i = 1; i < RETRY; i++) begin
      if (i == 5 || i == 9 || i == RETRY - 2) cyc(~m_lvl, 1'b0, 1'b0, "R9 R11");
      else cyc(m_lvl, 1'b0, 1'b0, "R9 R11");
    end
    // clear edge, then R10 resume and count restart
    cyc(m_lvl, 1'b0, 1'b0, "R10");
    for (int e = 1; e < TMO; e++) cyc(m_lvl, 1'b0, 1'b0, "R10");
    cyc(~m_lvl, 1'b0, 1'b0, "R10");
    for (int i = 0; i < DEAD + 4; i++) cyc(m_lvl, 1'b1, 1'b0, "R10");
    cyc(~m_lvl, 1'b1, 1'b0, "R10");
    for (int i = 0; i < DEAD + 2; i++) cyc(m_lvl, 1'b1, 1'b0, "R10");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule